// File: doc/BRIEF.md
# Watchdog Timer with Reset Generator

This block is an up-counting supervision timer. Software enables it and must keep rewriting its count register, usually with zero, often enough that the counter never wraps. The counter advances only on cycles where a prescaled tick input is high. If the counter wraps from its maximum value to zero while supervision is armed, the block responds in one of two ways, chosen by a control bit. It can start a system reset. In that case it produces an active-high internal reset pulse and a shorter active-low external reset pulse, and both pulses begin in the same cycle. Otherwise it raises a one-cycle non-maskable interrupt request.

The block also provides a plain count mode. In that mode a wrap only sets a status flag. A sticky source bit records what caused the most recent reset: the external reset pin or the timer. When both happen in the same cycle, the pin takes priority. Both pulse lengths are measured in system clock cycles and do not depend on the tick.

Top module: `wdt_rstgen`

## Requirements
- R1: The 8-bit counter (address 1) increases by one on each clock where `tick` is high and the run bit (control/status bit 5) is 1. It holds when the run bit is 0. A bus write to address 1 loads the written value, and the load takes precedence over a tick in the same cycle.
- R2: A wrap from 0xFF to 0x00 sets the overflow flag (control/status bit 7) whenever the run bit is 1.
- R3: A write of 0 to bit 7 clears the overflow flag only if a bus read of address 0 saw the flag at 1 after it was set. Without such a read, the write leaves the flag at 1. Writing 1 to bit 7 never sets the flag.
- R4: Supervision is armed when mode bit 6 and run bit 5 are both 1. With select bit 4 also at 1, a wrap drives `sys_rst_o` high from the next cycle for exactly 518 clock cycles.
- R5: That same wrap drives `ext_rst_n_o` low for exactly 132 clock cycles, starting in the same cycle as `sys_rst_o`. At all other times `ext_rst_n_o` is high.
- R6: With supervision armed and select bit 4 at 0, a wrap makes `nmi_o` high for exactly one cycle. `sys_rst_o` stays low and `ext_rst_n_o` stays high.
- R7: A timer reset clears the control bits, the overflow flag and the counter, and clears the source flag (bit 3, read-only) to 0. Bus writes are ignored while `sys_rst_o` is high.
- R8: When `pin_rst` is high, the next cycle shows `sys_rst_o` low, `ext_rst_n_o` high, `nmi_o` low, all control bits and the counter at 0, and the source flag at 1. A pulse already in progress is cut short.
- R9: If `pin_rst` is high in the same cycle that an armed wrap in reset mode occurs, the pin reset wins. No pulse starts and the source flag reads 1.
- R10: With mode bit 6 at 0, a wrap sets only the overflow flag. It produces no interrupt and no reset pulse, whatever the select bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pin_rst | input | 1 | External reset pin, synchronous, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = control/status, 1 = counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the address |
| tick | input | 1 | Prescaled count enable |
| sys_rst_o | output | 1 | Internal reset pulse, active high |
| ext_rst_n_o | output | 1 | External reset pulse, active low |
| nmi_o | output | 1 | Non-maskable interrupt request, one cycle |

## Verification
Two events can land in the same clock edge: an armed wrap in reset mode and an assertion of the external reset pin. The bench holds `tick` and `pin_rst` high together while the counter sits at 0xFF. It then requires that neither reset output moves on the next cycle and that the source flag reads back as 1. A second collision occurs when the pin is raised in the middle of a running pulse; the bench requires both outputs to return to idle one cycle later.

// File: rtl/wdt_rstgen_pkg.sv
package wdt_rstgen_pkg;
  localparam logic ADDR_CSR = 1'b0;
  localparam logic ADDR_CNT = 1'b1;
  localparam int BIT_OVF  = 7;
  localparam int BIT_MODE = 6;
  localparam int BIT_RUN  = 5;
  localparam int BIT_RSEL = 4;
  localparam int BIT_SRC  = 3;

  typedef struct packed {
    logic ovf;
    logic mode;
    logic run;
    logic rsel;
  } ctl_t;

  localparam ctl_t CTL_CLEAR = '{ovf: 1'b0, mode: 1'b0, run: 1'b0, rsel: 1'b0};
endpackage

// File: rtl/wdt_upcount.sv
module wdt_upcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  // wrap is the event for the edge now pending; a load overrides it
  assign wrap = en && tick && !ld && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (clr)           cnt <= '0;
    else if (ld)       cnt <= ld_val;
    else if (en && tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN        = 16,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic out
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);
  localparam logic IDLE = ACTIVE_LOW;

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (clr) begin
      out  <= IDLE;
      left <= '0;
    end else if (start) begin
      out  <= ~IDLE;
      left <= LAST;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end else begin
      out <= IDLE;
    end
  end
endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen
  import wdt_rstgen_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int INT_RST_CYC = 518,
  parameter int EXT_RST_CYC = 132
) (
  input  logic             clk,
  input  logic             pin_rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             tick,
  output logic             sys_rst_o,
  output logic             ext_rst_n_o,
  output logic             nmi_o
);
  localparam int PAD = CNT_W - 5;

  ctl_t             ctl;
  logic             src_q;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             wd_hit;
  logic             nmi_hit;
  logic             hold;
  logic             wr_csr;
  logic             wr_cnt;
  logic             ovf_clr;
  logic [CNT_W-1:0] csr_word;

  assign hold    = sys_rst_o;
  assign wr_csr  = bus_wr && (bus_addr == ADDR_CSR) && !hold;
  assign wr_cnt  = bus_wr && (bus_addr == ADDR_CNT) && !hold;
  assign wd_hit  = wrap && ctl.mode && ctl.rsel;
  assign nmi_hit = wrap && ctl.mode && !ctl.rsel;
  assign ovf_clr = wr_csr && !bus_wdata[BIT_OVF] && armed;
  assign csr_word = {ctl.ovf, ctl.mode, ctl.run, ctl.rsel, src_q, {PAD{1'b0}}};

  wdt_upcount #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .clr    (pin_rst || wd_hit || hold),
    .en     (ctl.run),
    .tick   (tick),
    .ld     (wr_cnt),
    .ld_val (bus_wdata),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  wdt_pulse #(.LEN(INT_RST_CYC), .ACTIVE_LOW(1'b0)) u_int_pulse (
    .clk   (clk),
    .clr   (pin_rst),
    .start (wd_hit),
    .out   (sys_rst_o)
  );

  wdt_pulse #(.LEN(EXT_RST_CYC), .ACTIVE_LOW(1'b1)) u_ext_pulse (
    .clk   (clk),
    .clr   (pin_rst),
    .start (wd_hit),
    .out   (ext_rst_n_o)
  );

  // reset cause: pin has priority over the timer
  always_ff @(posedge clk) begin
    if (pin_rst)     src_q <= 1'b1;
    else if (wd_hit) src_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (pin_rst || wd_hit || hold) begin
      ctl   <= CTL_CLEAR;
      armed <= 1'b0;
    end else begin
      if (wr_csr) begin
        ctl.mode <= bus_wdata[BIT_MODE];
        ctl.run  <= bus_wdata[BIT_RUN];
        ctl.rsel <= bus_wdata[BIT_RSEL];
      end
      if (wrap) begin
        ctl.ovf <= 1'b1;
      end else if (ovf_clr) begin
        ctl.ovf <= 1'b0;
        armed   <= 1'b0;
      end else if (bus_rd && (bus_addr == ADDR_CSR) && ctl.ovf) begin
        armed <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pin_rst) begin
      nmi_o     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      nmi_o     <= nmi_hit;
      bus_rdata <= (bus_addr == ADDR_CNT) ? cnt : csr_word;
    end
  end
endmodule

// File: rtl/wdt_rstgen_chk.sv
module wdt_rstgen_chk #(
  parameter int INT_RST_CYC = 518
) (
  input logic clk,
  input logic pin_rst,
  input logic sys_rst_o,
  input logic ext_rst_n_o,
  input logic nmi_o,
  input logic src_q
);
  int hcnt;

  always_ff @(posedge clk) begin
    if (pin_rst || !sys_rst_o) hcnt <= sys_rst_o ? 1 : 0;
    else                       hcnt <= hcnt + 1;
  end

  p_int_len_r4: assert property (@(posedge clk) disable iff (pin_rst)
    ($fell(sys_rst_o) && !$past(pin_rst)) |-> (hcnt == INT_RST_CYC));

  p_int_max_r4: assert property (@(posedge clk) disable iff (pin_rst)
    hcnt <= INT_RST_CYC);

  p_ext_inside_r5: assert property (@(posedge clk) disable iff (pin_rst)
    !ext_rst_n_o |-> sys_rst_o);

  p_start_together_r5: assert property (@(posedge clk) disable iff (pin_rst)
    $rose(sys_rst_o) |-> !ext_rst_n_o);

  p_nmi_single_r6: assert property (@(posedge clk) disable iff (pin_rst)
    nmi_o |=> !nmi_o);

  p_nmi_quiet_r6: assert property (@(posedge clk) disable iff (pin_rst)
    nmi_o |-> (ext_rst_n_o && !sys_rst_o));

  p_src_clear_r7: assert property (@(posedge clk) disable iff (pin_rst)
    $rose(sys_rst_o) |-> !src_q);

  p_pin_wins_r8: assert property (@(posedge clk)
    pin_rst |=> (src_q && !sys_rst_o && ext_rst_n_o && !nmi_o));
endmodule

bind wdt_rstgen wdt_rstgen_chk #(.INT_RST_CYC(INT_RST_CYC)) u_chk (
  .clk         (clk),
  .pin_rst     (pin_rst),
  .sys_rst_o   (sys_rst_o),
  .ext_rst_n_o (ext_rst_n_o),
  .nmi_o       (nmi_o),
  .src_q       (src_q)
);

// File: tb/wdt_rstgen_test.sv
module wdt_rstgen_test;
  logic       clk = 1'b0;
  logic       pin_rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick = 1'b0;
  logic       sys_rst_o, ext_rst_n_o, nmi_o;

  int checks = 0;
  int failures = 0;
  logic rd_d = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  wdt_rstgen uut (
    .clk(clk), .pin_rst(pin_rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .sys_rst_o(sys_rst_o), .ext_rst_n_o(ext_rst_n_o), .nmi_o(nmi_o)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: compares each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_d && expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      checks++;
      if (bus_rdata !== e.val) begin
        failures++;
        $display("FAIL %s read actual=%02h expected=%02h", e.req, bus_rdata, e.val);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic a, input logic [7:0] v, input string req);
    exp_t e;
    e.val = v; e.req = req;
    expq.push_back(e);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic one_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int ni, ne;
    repeat (3) @(negedge clk);
    pin_rst = 1'b0;
    // R8 reset state
    chk("R8 sys_rst idle", sys_rst_o, 1'b0);
    chk("R8 ext_rst_n idle", ext_rst_n_o, 1'b1);
    chk("R8 nmi idle", nmi_o, 1'b0);
    rd_expect(1'b0, 8'h08, "R8 csr after pin reset");
    rd_expect(1'b1, 8'h00, "R8 counter after pin reset");

    // R1 counting, hold, load
    wr(1'b1, 8'h10);
    rd_expect(1'b1, 8'h10, "R1 load");
    wr(1'b0, 8'h20);
    tick = 1'b1; repeat (3) @(negedge clk); tick = 1'b0;
    rd_expect(1'b1, 8'h13, "R1 three ticks");
    wr(1'b0, 8'h00);
    tick = 1'b1; repeat (2) @(negedge clk); tick = 1'b0;
    rd_expect(1'b1, 8'h13, "R1 hold when stopped");

    // R10, R2, R3: plain count mode overflow
    wr(1'b0, 8'h30);
    wr(1'b1, 8'hFF);
    one_tick();
    chk("R10 no nmi", nmi_o, 1'b0);
    chk("R10 no sys_rst", sys_rst_o, 1'b0);
    chk("R10 no ext_rst", ext_rst_n_o, 1'b1);
    rd_expect(1'b1, 8'h00, "R2 counter wrapped");
    wr(1'b0, 8'h30);
    rd_expect(1'b0, 8'hB8, "R3 flag kept without read");
    wr(1'b0, 8'h30);
    rd_expect(1'b0, 8'h38, "R3 flag cleared after read");
    wr(1'b0, 8'hB0);
    rd_expect(1'b0, 8'h38, "R3 write 1 does not set");

    // R6: interrupt mode
    wr(1'b0, 8'h60);
    wr(1'b1, 8'hFF);
    one_tick();
    chk("R6 nmi high", nmi_o, 1'b1);
    chk("R6 ext stays high", ext_rst_n_o, 1'b1);
    chk("R6 sys stays low", sys_rst_o, 1'b0);
    @(negedge clk);
    chk("R6 nmi one cycle", nmi_o, 1'b0);
    rd_expect(1'b0, 8'hE8, "R2 R6 flag set");

    // R4, R5, R7: reset mode
    wr(1'b0, 8'h70);
    wr(1'b1, 8'hFF);
    one_tick();
    chk("R4 sys_rst starts", sys_rst_o, 1'b1);
    chk("R5 ext_rst starts together", ext_rst_n_o, 1'b0);
    ni = 0; ne = 0;
    for (int i = 0; i < 700; i++) begin
      if (sys_rst_o) ni++;
      if (!ext_rst_n_o) ne++;
      if (i == 5) begin bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h70; end
      if (i == 6) begin bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h55; end
      if (i == 7) bus_wr = 1'b0;
      @(negedge clk);
    end
    chk_int("R4 internal pulse length", ni, 518);
    chk_int("R5 external pulse length", ne, 132);
    rd_expect(1'b0, 8'h00, "R7 csr cleared, source=timer");
    rd_expect(1'b1, 8'h00, "R7 counter cleared, writes ignored");

    // R9: pin reset and overflow in the same cycle
    wr(1'b0, 8'h70);
    wr(1'b1, 8'hFF);
    tick = 1'b1; pin_rst = 1'b1;
    @(negedge clk);
    tick = 1'b0; pin_rst = 1'b0;
    chk("R9 no internal pulse", sys_rst_o, 1'b0);
    chk("R9 no external pulse", ext_rst_n_o, 1'b1);
    rd_expect(1'b0, 8'h08, "R9 source flag is pin");

    // R8: pin reset cuts a running pulse
    wr(1'b0, 8'h70);
    wr(1'b1, 8'hFF);
    one_tick();
    repeat (20) @(negedge clk);
    chk("R8 pulse running", sys_rst_o, 1'b1);
    pin_rst = 1'b1;
    @(negedge clk);
    pin_rst = 1'b0;
    chk("R8 sys_rst cut", sys_rst_o, 1'b0);
    chk("R8 ext_rst cut", ext_rst_n_o, 1'b1);
    rd_expect(1'b0, 8'h08, "R8 source after abort");
    @(negedge clk);
    chk_int("scoreboard drained", expq.size(), 0);
    summary();
  end
endmodule